// File: doc/BRIEF.md
# Accumulator Processor with Microsequenced Bus Control

This block is a small accumulator processor built around one shared internal data bus. A sequencer steps through a fixed list of micro-steps for each instruction, one step per clock. In each step it picks at most one bus source (the memory read data or the ALU result) and raises the write enables of the registers that capture the bus. The registers are a program counter, an instruction opcode register, an operand address register, the accumulator, a B operand register and a carry/zero flag pair.

Instructions are two bytes long except the no-op, which is one byte. The opcode sits in bits [7:6] of the first byte and the second byte holds an 8-bit memory address. The memory port is synchronous: the block drives an address and pulls an active-low read line for one cycle, and the memory returns the data in the following cycle. The accumulator, program counter, flags and the per-cycle bus-source strobes are brought out so that the instruction flow can be observed.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low, `pc_o`, `acc_o`, `carry_o`, `zero_o` and `bus_drv_o` are all zero. The internal reset clears two clock edges after `rst_n` rises, and the first instruction fetch then reads address 0.
- R2: Every instruction starts with a read of address `pc_o` (read line low for one cycle). In the next cycle the memory drives the bus, the opcode is taken from bits [7:6] of that byte (bits [5:0] are ignored), and `pc_o` then advances by one.
- R3: Opcode 01 (load) runs for 6 cycles: fetch, a read of the operand address byte at the next location, a read from that operand address, and then the accumulator takes the returned byte. The flags are left unchanged.
- R4: Opcode 10 (add) runs for 7 cycles. The operand byte goes into the B register. In a final cycle the ALU drives the bus with function code binary 10, and the accumulator takes (accumulator + operand) mod 256.
- R5: Only an add updates the flags. Carry is the ninth bit of the 8-bit sum, and zero is set when the 8-bit result is 0x00.
- R6: Opcode 11 (jump) runs for 4 cycles. The operand byte is loaded into `pc_o`, and the next fetch reads that address.
- R7: Opcode 00 is a one-byte no-op lasting 3 cycles. Only `pc_o` changes, by +1. The accumulator and the flags are not affected.
- R8: In each cycle at most one bit of `bus_drv_o` is set. Bit 0 (memory) is set only in the cycle after a read. Bit 1 (ALU) is set only in the last cycle of an add.
- R9: `mem_rd_n_o` is never low in two consecutive cycles. `mem_addr_o` carries the program counter for opcode and address-byte reads, and the operand address for data reads. `mem_wr_n_o` stays high, and `mem_wdata_o` shows the accumulator.
- R10: The program counter wraps from 0xFF to 0x00, both on increment and on instructions that straddle the end of memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_rd_n_o | output | 1 | Active-low read strobe, data expected the next cycle |
| mem_wr_n_o | output | 1 | Active-low write strobe (held inactive) |
| mem_wdata_o | output | DATA_W | Outbound data, shows the accumulator |
| mem_rdata_i | input | DATA_W | Read data, valid the cycle after a read strobe |
| pc_o | output | ADDR_W | Program counter |
| acc_o | output | DATA_W | Accumulator |
| carry_o | output | 1 | Carry flag from the last add |
| zero_o | output | 1 | Zero flag from the last add |
| bus_drv_o | output | 2 | Bus source strobes: bit 0 memory, bit 1 ALU |

## Verification
The bench uses the default parameters: 8-bit data, 8-bit addresses and two reset synchronizer stages. With a 256-byte address space, a short program can place a jump target at 0xFE so that an add straddles the end of memory and the counter wraps. With 8-bit sums, carry-out and a zero result are reached with small operands such as 0x0C + 0xF4. The program mixes every opcode, including opcode bytes with non-zero low bits. The run also includes a reset in the middle of execution, which exercises the synchronized reset release.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_W   = 2;
  localparam int N_SRC   = 2;
  localparam int SRC_MEM = 0;
  localparam int SRC_ALU = 1;

  typedef enum logic [2:0] {
    ST_FETCH_A = 3'd0,
    ST_FETCH_D = 3'd1,
    ST_DECODE  = 3'd2,
    ST_OPND_D  = 3'd3,
    ST_EXEC_A  = 3'd4,
    ST_EXEC_D  = 3'd5,
    ST_ALU     = 3'd6
  } step_e;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP  = 2'b00,
    OP_LOAD = 2'b01,
    OP_ADD  = 2'b10,
    OP_JUMP = 2'b11
  } opc_e;

  typedef enum logic [1:0] {
    ALU_PASS = 2'b00,
    ALU_ADD  = 2'b10
  } alu_fn_e;

  typedef struct packed {
    logic [N_SRC-1:0] drv;
    logic             ir_we;
    logic             mar_we;
    logic             pc_ld;
    logic             pc_inc;
    logic             acc_we;
    logic             b_we;
    logic             flg_we;
    logic             rd;
    logic             addr_mar;
    alu_fn_e          alu_fn;
  } ctl_t;

endpackage

// File: rtl/acc_cpu_rst_sync.sv
module acc_cpu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  opc_e  opcode,
  output step_e step,
  output ctl_t  ctl
);

  step_e step_q;
  step_e step_d;

  // next-step selection
  always_comb begin
    step_d = ST_FETCH_A;
    case (step_q)
      ST_FETCH_A: step_d = ST_FETCH_D;
      ST_FETCH_D: step_d = ST_DECODE;
      ST_DECODE:  step_d = (opcode == OP_NOP) ? ST_FETCH_A : ST_OPND_D;
      ST_OPND_D:  step_d = (opcode == OP_JUMP) ? ST_FETCH_A : ST_EXEC_A;
      ST_EXEC_A:  step_d = ST_EXEC_D;
      ST_EXEC_D:  step_d = (opcode == OP_ADD) ? ST_ALU : ST_FETCH_A;
      ST_ALU:     step_d = ST_FETCH_A;
      default:    step_d = ST_FETCH_A;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_FETCH_A;
    else        step_q <= step_d;
  end

  // per-step strobes
  always_comb begin
    ctl        = '0;
    ctl.alu_fn = ALU_PASS;
    case (step_q)
      ST_FETCH_A: begin
        ctl.rd = 1'b1;
      end
      ST_FETCH_D: begin
        ctl.drv[SRC_MEM] = 1'b1;
        ctl.ir_we        = 1'b1;
        ctl.pc_inc       = 1'b1;
      end
      ST_DECODE: begin
        ctl.rd = (opcode != OP_NOP);
      end
      ST_OPND_D: begin
        ctl.drv[SRC_MEM] = 1'b1;
        if (opcode == OP_JUMP) begin
          ctl.pc_ld = 1'b1;
        end else begin
          ctl.mar_we = 1'b1;
          ctl.pc_inc = 1'b1;
        end
      end
      ST_EXEC_A: begin
        ctl.rd       = 1'b1;
        ctl.addr_mar = 1'b1;
      end
      ST_EXEC_D: begin
        ctl.drv[SRC_MEM] = 1'b1;
        ctl.acc_we       = (opcode == OP_LOAD);
        ctl.b_we         = (opcode == OP_ADD);
      end
      ST_ALU: begin
        ctl.drv[SRC_ALU] = 1'b1;
        ctl.alu_fn       = ALU_ADD;
        ctl.acc_we       = 1'b1;
        ctl.flg_we       = 1'b1;
      end
      default: ;
    endcase
  end

  assign step = step_q;

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_fn_e           fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y,
  output logic              carry
);

  logic [DATA_W:0] sum;

  always_comb begin
    sum = {1'b0, a} + {1'b0, b};
    case (fn)
      ALU_ADD: begin
        y     = sum[DATA_W-1:0];
        carry = sum[DATA_W];
      end
      default: begin
        y     = b;
        carry = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/acc_cpu_bus.sv
module acc_cpu_bus #(
  parameter int DATA_W = 8,
  parameter int N_SRC  = 2
) (
  input  logic [N_SRC-1:0]             drv,
  input  logic [N_SRC-1:0][DATA_W-1:0] src,
  output logic [DATA_W-1:0]            bus
);

  logic [N_SRC-1:0][DATA_W-1:0] gated;

  generate
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
      assign gated[g] = src[g] & {DATA_W{drv[g]}};
    end
  endgenerate

  always_comb begin
    bus = '0;
    for (int i = 0; i < N_SRC; i++) bus = bus | gated[i];
  end

endmodule

// File: rtl/acc_cpu_regs.sv
module acc_cpu_regs
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus,
  input  logic              alu_carry,
  input  logic              ir_we,
  input  logic              mar_we,
  input  logic              pc_ld,
  input  logic              pc_inc,
  input  logic              acc_we,
  input  logic              b_we,
  input  logic              flg_we,
  output logic [OPC_W-1:0]  opc,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] b,
  output logic              carry,
  output logic              zero
);

  localparam int OPC_LSB = DATA_W - OPC_W;

  logic [OPC_W-1:0]  opc_d;
  logic [ADDR_W-1:0] pc_d, mar_d;
  logic [DATA_W-1:0] acc_d, b_d;
  logic              carry_d, zero_d;

  always_comb begin
    opc_d   = ir_we  ? bus[DATA_W-1:OPC_LSB] : opc;
    mar_d   = mar_we ? bus[ADDR_W-1:0]       : mar;
    acc_d   = acc_we ? bus                   : acc;
    b_d     = b_we   ? bus                   : b;
    carry_d = flg_we ? alu_carry             : carry;
    zero_d  = flg_we ? (bus == '0)           : zero;
    if (pc_ld)       pc_d = bus[ADDR_W-1:0];
    else if (pc_inc) pc_d = pc + 1'b1;
    else             pc_d = pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc   <= '0;
      pc    <= '0;
      mar   <= '0;
      acc   <= '0;
      b     <= '0;
      carry <= 1'b0;
      zero  <= 1'b0;
    end else begin
      opc   <= opc_d;
      pc    <= pc_d;
      mar   <= mar_d;
      acc   <= acc_d;
      b     <= b_d;
      carry <= carry_d;
      zero  <= zero_d;
    end
  end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 8,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_n_o,
  output logic              mem_wr_n_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              carry_o,
  output logic              zero_o,
  output logic [N_SRC-1:0]  bus_drv_o
);

  logic                         rst_sync_n;
  step_e                        step;
  ctl_t                         ctl;
  opc_e                         opcode;
  logic [OPC_W-1:0]             ir_opc;
  logic [ADDR_W-1:0]            pc, mar;
  logic [DATA_W-1:0]            acc, b_reg, bus, alu_y;
  logic                         alu_c, carry, zero;
  logic [N_SRC-1:0][DATA_W-1:0] srcs;

  acc_cpu_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign opcode = opc_e'(ir_opc);

  acc_cpu_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n), .opcode(opcode), .step(step), .ctl(ctl)
  );

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .fn(ctl.alu_fn), .a(acc), .b(b_reg), .y(alu_y), .carry(alu_c)
  );

  assign srcs[SRC_MEM] = mem_rdata_i;
  assign srcs[SRC_ALU] = alu_y;

  acc_cpu_bus #(.DATA_W(DATA_W), .N_SRC(N_SRC)) u_bus (
    .drv(ctl.drv), .src(srcs), .bus(bus)
  );

  acc_cpu_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .bus(bus), .alu_carry(alu_c),
    .ir_we(ctl.ir_we), .mar_we(ctl.mar_we), .pc_ld(ctl.pc_ld),
    .pc_inc(ctl.pc_inc), .acc_we(ctl.acc_we), .b_we(ctl.b_we),
    .flg_we(ctl.flg_we), .opc(ir_opc), .pc(pc), .mar(mar), .acc(acc),
    .b(b_reg), .carry(carry), .zero(zero)
  );

  assign mem_addr_o  = ctl.addr_mar ? mar : pc;
  assign mem_rd_n_o  = ~ctl.rd;
  assign mem_wr_n_o  = 1'b1;
  assign mem_wdata_o = acc;
  assign pc_o        = pc;
  assign acc_o       = acc;
  assign carry_o     = carry;
  assign zero_o      = zero;
  assign bus_drv_o   = ctl.drv;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input step_e             step,
  input opc_e              opcode,
  input logic [N_SRC-1:0]  bus_drv,
  input logic              mem_rd_n,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] acc,
  input logic              carry,
  input logic              zero,
  input alu_fn_e           alu_fn
);

  p_one_driver_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_drv));

  p_mem_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drv[SRC_MEM] |-> $past(!mem_rd_n));

  p_read_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_n |=> mem_rd_n);

  p_fetch_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_FETCH_D) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

  p_alu_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drv[SRC_ALU] |-> (alu_fn == ALU_ADD));

  p_flags_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_drv[SRC_ALU] |=> $stable({carry, zero}));

  p_jump_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_OPND_D && opcode == OP_JUMP) |=> (step == ST_FETCH_A));

  p_nop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_DECODE && opcode == OP_NOP) |=>
      ($stable(acc) && step == ST_FETCH_A));

endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .step(step), .opcode(opcode),
  .bus_drv(bus_drv_o), .mem_rd_n(mem_rd_n_o), .pc(pc_o), .acc(acc_o),
  .carry(carry_o), .zero(zero_o), .alu_fn(ctl.alu_fn)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata, pc, acc;
  logic       mem_rd_n, mem_wr_n, carry, zero;
  logic [1:0] bus_drv;

  always #4 clk = ~clk;

  acc_cpu u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr_o(mem_addr), .mem_rd_n_o(mem_rd_n),
    .mem_wr_n_o(mem_wr_n), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .pc_o(pc), .acc_o(acc), .carry_o(carry), .zero_o(zero), .bus_drv_o(bus_drv)
  );

  // behavioural synchronous memory: data appears the cycle after a read
  logic [7:0] mem [256];
  always @(posedge clk) if (!mem_rd_n) mem_rdata <= mem[mem_addr];

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit running = 0, done = 0;

  typedef struct {
    logic [7:0] pc, acc, addr;
    logic       c, z, rd_n;
    logic [1:0] drv;
    string      tag;
  } exp_t;
  exp_t q[$];
  logic [7:0] m_pc, m_acc;
  logic       m_c, m_z;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(logic [7:0] p, logic rd_n, logic [7:0] a, logic [1:0] d, string tag);
    exp_t e;
    e.pc = p; e.acc = m_acc; e.c = m_c; e.z = m_z;
    e.rd_n = rd_n; e.addr = a; e.drv = d; e.tag = tag;
    q.push_back(e);
  endtask

  // expands one instruction into its expected cycle records
  task automatic gen_instr();
    logic [7:0] p0, p1, p2, tgt, dat;
    logic [1:0] op;
    logic [8:0] sum;
    string      t;
    p0 = m_pc; p1 = p0 + 8'd1; p2 = p0 + 8'd2;
    op = mem[p0][7:6];
    t  = (p0 == 8'hFE) ? "R10" : "R2";
    push(p0, 1'b0, p0, 2'b00, t);
    push(p0, 1'b1, 8'h00, 2'b01, t);
    if (op == 2'b00) begin
      push(p1, 1'b1, 8'h00, 2'b00, "R7");
      m_pc = p1;
      return;
    end
    t = (p0 == 8'hFE) ? "R10" : (op == 2'b11) ? "R6" : (op == 2'b01) ? "R3" : "R4";
    tgt = mem[p1];
    push(p1, 1'b0, p1, 2'b00, t);
    push(p1, 1'b1, 8'h00, 2'b01, t);
    if (op == 2'b11) begin
      m_pc = tgt;
      return;
    end
    dat = mem[tgt];
    push(p2, 1'b0, tgt, 2'b00, t);
    push(p2, 1'b1, 8'h00, 2'b01, t);
    m_pc = p2;
    if (op == 2'b01) begin
      m_acc = dat;
      return;
    end
    push(p2, 1'b1, 8'h00, 2'b10, t);
    sum = {1'b0, m_acc} + {1'b0, dat};
    m_acc = sum[7:0]; m_c = sum[8]; m_z = (sum[7:0] == 8'h00);
  endtask

  task automatic model_restart();
    q.delete();
    m_pc = 8'h00; m_acc = 8'h00; m_c = 1'b0; m_z = 1'b0;
    push(8'h00, 1'b0, 8'h00, 2'b00, "R1");  // synchronizer hold cycles
    push(8'h00, 1'b0, 8'h00, 2'b00, "R1");
  endtask

  task automatic check_reset();
    chk("R1", "pc", pc, 0);
    chk("R1", "acc", acc, 0);
    chk("R1", "carry", carry, 0);
    chk("R1", "zero", zero, 0);
    chk("R1", "bus_drv", bus_drv, 0);
  endtask

  always @(negedge clk) begin
    if (running) begin
      exp_t e;
      if (q.size() == 0) gen_instr();
      e = q.pop_front();
      chk(e.tag, "pc", pc, e.pc);
      chk(e.tag, "acc", acc, e.acc);
      chk("R5", "carry", carry, e.c);
      chk("R5", "zero", zero, e.z);
      chk("R9", "rd_n", mem_rd_n, e.rd_n);
      if (!e.rd_n) chk("R9", "addr", mem_addr, e.addr);
      chk("R9", "wr_n", mem_wr_n, 1);
      chk("R9", "wdata", mem_wdata, e.acc);
      chk("R8", "bus_drv", bus_drv, e.drv);
      chk("R8", "driver count", $countones(bus_drv) <= 1, 1);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    // program: load, adds with carry/zero, no-ops, jumps, junk low opcode bits
    mem[8'h00] = 8'h40; mem[8'h01] = 8'h80;
    mem[8'h02] = 8'h80; mem[8'h03] = 8'h81;
    mem[8'h04] = 8'h00;
    mem[8'h05] = 8'h80; mem[8'h06] = 8'h82;
    mem[8'h07] = 8'h80; mem[8'h08] = 8'h83;
    mem[8'h09] = 8'hC0; mem[8'h0A] = 8'h20;
    mem[8'h20] = 8'h80; mem[8'h21] = 8'h85;
    mem[8'h22] = 8'h7F; mem[8'h23] = 8'h86;
    mem[8'h24] = 8'h3A;
    mem[8'h25] = 8'h9C; mem[8'h26] = 8'h87;
    mem[8'h27] = 8'hC5; mem[8'h28] = 8'hFE;
    mem[8'hFE] = 8'h80; mem[8'hFF] = 8'h88;
    mem[8'h80] = 8'h05; mem[8'h81] = 8'h07; mem[8'h82] = 8'hF4;
    mem[8'h83] = 8'hFF; mem[8'h85] = 8'h01; mem[8'h86] = 8'h33;
    mem[8'h87] = 8'h40; mem[8'h88] = 8'h0D;

    repeat (3) @(negedge clk);
    check_reset();                       // R1 at power-up
    @(posedge clk); #2;
    rst_n = 1'b1;
    model_restart();
    running = 1;
    repeat (600) @(negedge clk);

    @(posedge clk); #2;                  // R1 reset in mid-run
    rst_n = 1'b0;
    running = 0;
    repeat (2) @(negedge clk);
    check_reset();
    @(posedge clk); #2;
    rst_n = 1'b1;
    model_restart();
    running = 1;
    repeat (300) @(negedge clk);

    running = 0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule